// File: doc/BRIEF.md
# Real-Time I/O Reservation Controller

This block decides which of several peripheral bridges may move data into shared main memory. Each bridge buffers its own traffic and raises a ready line when data is waiting. The controller answers with one block line per bridge and lowers at most one of them at a time. The chosen bridge is the one whose flow has the shortest replenishment period, which gives rate-monotonic priority.

Each flow holds a budget of clock ticks. The budget is spent while the flow is unblocked and ready. It is restored in the manner of a sporadic server: the ticks spent in an interval come back one period after that interval's first spent tick. Budgets and periods are written through a small configuration port while the controller is disabled.

With the enable low the block is in bypass. In bypass every block line is held low, so that the bridges run without any reservation.

Top module: `rt_io_reserve`

## Requirements
- R1: While `en` is low, every bit of `blk` is 0, no grant is held, and each flow's remaining budget is reloaded from its configured budget on every tick, with a write in that tick applied first.
- R2: While `en` is high, at most one bit of `blk` is 0.
- R3: A flow is eligible in a tick when its `rdy` bit is 1 and its remaining budget is nonzero. If no grant is held, the eligible flow with the smallest period is unblocked from the next tick. A tie in period goes to the lowest flow index.
- R4: Each tick in which a flow is unblocked with `rdy` high lowers its remaining budget by one. A flow whose remaining budget is zero is blocked at once.
- R5: The first spent tick c0 of a flow with no open interval opens an interval. At tick c0+P, with P the flow's period, every tick spent in c0..c0+P-1 is returned to the budget. Spending in tick c0+P opens a new interval. The returned budget counts for eligibility from tick c0+P+1.
- R6: If a grant is held and the current winner is another flow, or there is no eligible flow, all flows are blocked in the next tick. The new winner is unblocked in the tick after that.
- R7: A granted flow whose `rdy` falls in a tick loses its grant, and all flows are blocked from the next tick.
- R8: A write with `cfg_we` high sets the budget (`cfg_kind`=0) or the period (`cfg_kind`=1) of flow `cfg_flow` to `cfg_val`. It takes effect only while `en` is low and is ignored while `en` is high.
- R9: After reset, all budgets and periods are 0, so enabling without configuration keeps every flow blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of budget and period per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | 1 = reservation active, 0 = bypass and configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 = budget, 1 = period |
| cfg_flow | input | IW | Flow index of the write |
| cfg_val | input | W | Value written |
| rdy | input | NF | Per-bridge data-waiting lines |
| blk | output | NF | Per-bridge block lines, 1 = must not transfer |

## Verification
Several properties are checked on every cycle: no two flows are unblocked together, a flow is never unblocked unless it was ready in the cycle before, a change of owner always passes through an all-blocked cycle, and remaining plus spent budget always equals the configured budget. Which flow wins, when budget returns after its period, how ties resolve, and whether writes made while enabled are ignored can only be shown by the bench's scenarios. There, a behavioural model that tracks interval deadlines by absolute tick number predicts every block line in every cycle.

// File: rtl/rt_io_reserve.sv
`timescale 1ns/1ps
module rt_io_reserve #(
  parameter int NF = 4,
  parameter int W  = 8,
  localparam int IW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cfg_we,
  input  logic          cfg_kind,
  input  logic [IW-1:0] cfg_flow,
  input  logic [W-1:0]  cfg_val,
  input  logic [NF-1:0] rdy,
  output logic [NF-1:0] blk
);

  logic [NF-1:0][W-1:0] per_v;
  logic [NF-1:0]        elig;
  logic                 gv;
  logic [IW-1:0]        gi;
  logic                 found;
  logic [IW-1:0]        best;
  logic [W-1:0]         bestp;

  always_comb begin
    found = 1'b0;
    best  = '0;
    bestp = '0;
    for (int i = 0; i < NF; i++)
      if (elig[i] && (!found || per_v[i] < bestp)) begin
        found = 1'b1;
        best  = IW'(i);
        bestp = per_v[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      gv <= 1'b0;
      gi <= '0;
    end else if (gv) begin
      if (!found || best != gi) gv <= 1'b0;
    end else if (found) begin
      gv <= 1'b1;
      gi <= best;
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_flow
    logic [W-1:0] bud, per, rem, cnt, used, nb;
    logic         live, take, hit;

    assign hit      = cfg_we && (cfg_flow == IW'(i));
    assign nb       = (hit && !cfg_kind) ? cfg_val : bud;
    assign per_v[i] = per;
    assign elig[i]  = rdy[i] && (rem != '0);
    assign live     = en && gv && (gi == IW'(i)) && (rem != '0);
    assign take     = live && rdy[i];
    assign blk[i]   = en && !live;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bud <= '0; per <= '0; rem <= '0; cnt <= '0; used <= '0;
      end else if (!en) begin
        bud  <= nb;
        if (hit && cfg_kind) per <= cfg_val;
        rem  <= nb;
        cnt  <= '0;
        used <= '0;
      end else if (cnt == W'(1)) begin
        rem  <= rem + used - W'(take);
        used <= W'(take);
        cnt  <= take ? per : '0;
      end else begin
        rem  <= rem - W'(take);
        used <= used + W'(take);
        if (cnt != '0) cnt <= cnt - W'(1);
        else if (take) cnt <= per;
      end
    end

    a_r4_budget_sum: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ({1'b0, rem} + {1'b0, used}) == {1'b0, bud});

    a_r3_ready_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !blk[i]) |-> $past(rdy[i]));
  end

  a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $onehot0(~blk));

  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (blk == '0));

  a_r6_dead_time: assert property (@(posedge clk) disable iff (!rst_n)
    (en && blk != '1) |=> (!en || blk == '1 || blk == $past(blk)));

endmodule

// File: tb/sim_rt_io_reserve.sv
`timescale 1ns/1ps
module sim_rt_io_reserve;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_kind = 1'b0;
  logic [1:0] cfg_flow = '0;
  logic [7:0] cfg_val = '0;
  logic [3:0] rdy = '0;
  logic [3:0] blk;

  always #10 clk = ~clk;

  rt_io_reserve #(.NF(4), .W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_flow(cfg_flow), .cfg_val(cfg_val), .rdy(rdy), .blk(blk)
  );

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R9";
  bit    cmp_on = 1'b0;
  bit    done   = 1'b0;
  int    seen1  = 0;

  int m_bud[4], m_per[4], m_rem[4], m_used[4], m_dl[4];
  bit m_open[4];
  bit m_gv;
  int m_gi;
  int tick = 0;

  task automatic chk(string r, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at tick %0d: blk actual=%b expected=%b", r, tick, act, exp);
    end
  endtask

  function automatic logic [3:0] m_exp();
    logic [3:0] e;
    if (!en) return 4'b0000;
    e = 4'b1111;
    if (m_gv && m_rem[m_gi] > 0) e[m_gi] = 1'b0;
    return e;
  endfunction

  always @(posedge clk) begin
    int bi;
    bit tk[4];
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_bud[i] = 0; m_per[i] = 0; m_rem[i] = 0; m_used[i] = 0;
        m_dl[i] = 0; m_open[i] = 0;
      end
      m_gv = 0; m_gi = 0;
    end else if (!en) begin
      if (cfg_we) begin
        if (cfg_kind) m_per[cfg_flow] = cfg_val;
        else m_bud[cfg_flow] = cfg_val;
      end
      for (int i = 0; i < 4; i++) begin
        m_rem[i] = m_bud[i]; m_used[i] = 0; m_open[i] = 0;
      end
      m_gv = 0;
    end else begin
      bi = -1;
      for (int i = 0; i < 4; i++)
        if (rdy[i] && m_rem[i] > 0 && (bi < 0 || m_per[i] < m_per[bi])) bi = i;
      for (int i = 0; i < 4; i++)
        tk[i] = m_gv && m_gi == i && m_rem[i] > 0 && rdy[i];
      for (int i = 0; i < 4; i++) begin
        if (m_open[i] && m_dl[i] == tick) begin
          m_rem[i] += m_used[i]; m_used[i] = 0; m_open[i] = 0;
        end
        if (tk[i]) begin
          m_rem[i]--; m_used[i]++;
          if (!m_open[i]) begin m_open[i] = 1; m_dl[i] = tick + m_per[i]; end
        end
      end
      if (m_gv) begin
        if (bi != m_gi) m_gv = 0;
      end else if (bi >= 0) begin
        m_gv = 1; m_gi = bi;
      end
    end
    tick++;
  end

  always @(negedge clk)
    if (cmp_on && !done) begin
      chk(tag, blk, m_exp());
      if (tag == "R8" && blk[1] == 1'b0) seen1++;
    end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(bit kind, int flow, int val);
    cfg_we = 1'b1; cfg_kind = kind; cfg_flow = 2'(flow); cfg_val = 8'(val);
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", blk, 4'b0000);
    step(1);
    cmp_on = 1'b1;

    tag = "R9";
    en = 1'b1; rdy = 4'b1111;
    step(4);
    @(negedge clk);
    chk("R9", blk, 4'b1111);
    step(1);
    en = 1'b0; rdy = 4'b0000;
    step(1);

    for (int f = 0; f < 3; f++) begin
      wr(0, f, 9);
      wr(1, f, 72);
    end
    wr(0, 3, 5);
    wr(1, 3, 8);
    tag = "R2 R3 R4 R5 R6";
    en = 1'b1; rdy = 4'b1111;
    step(400);

    tag = "R1";
    en = 1'b0;
    @(negedge clk);
    chk("R1", blk, 4'b0000);
    step(2);

    tag = "R3";
    en = 1'b1; rdy = 4'b0110;
    @(negedge clk);
    chk("R3", blk, 4'b1111);
    @(negedge clk);
    chk("R3", blk, 4'b1101);
    step(20);
    en = 1'b0; rdy = 4'b0000;
    step(1);

    tag = "R5";
    wr(0, 2, 2);
    wr(1, 2, 10);
    en = 1'b1; rdy = 4'b0100;
    step(80);
    en = 1'b0;
    step(1);

    wr(0, 0, 6);  wr(1, 0, 20);
    wr(0, 1, 3);  wr(1, 1, 12);
    wr(0, 2, 10); wr(1, 2, 40);
    wr(0, 3, 2);  wr(1, 3, 12);
    tag = "R6 R7";
    en = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      if ($urandom % 4 == 0) rdy = 4'($urandom);
      step(1);
    end

    tag = "R8";
    rdy = 4'b0010;
    wr(0, 1, 0);
    wr(1, 1, 0);
    step(60);
    checks++;
    if (seen1 == 0) begin
      fails++;
      $display("FAIL R8: grant cycles for flow 1 after ignored write actual=%0d expected>0", seen1);
    end

    tag = "R1";
    en = 1'b0; rdy = 4'b1111;
    @(negedge clk);
    chk("R1", blk, 4'b0000);
    step(2);

    done = 1'b1;
    summary();
  end
endmodule